// File: doc/BRIEF.md
# Split-Address I/O Bridge with Configuration Window

This block connects the simple command/response I/O master port of a processor to two targets. The port carries 16-bit addresses and 32-bit data words. One 16-bit address space is split into two fixed regions. The lower 60 KB passes straight through, without protocol conversion, to a frame-buffer memory port that speaks the same command/response protocol and answers one cycle later. The top 4 KB is a configuration window. Accesses there are converted into Wishbone classic single cycles on a slave port with a 12-bit address.

Only one transaction is in flight at a time. While a Wishbone cycle is open, the bridge holds off the master by lowering its accept signal. When the selected target finishes, the master gets a one-cycle response, and on a read the data word arrives in that same cycle. The configuration window covers the top of the space, so the top 4 KB of a full 64 KB buffer cannot be reached.

Top module: `cfgwin_bridge`

## Requirements
- R1: A command whose address is in 0x0000..0xEFFF is issued on the memory port in the cycle it is accepted, and it opens no Wishbone cycle. The command codes are IDLE=0, WRITE=1 and READ=2.
- R2: A command whose address is in 0xF000..0xFFFF opens a Wishbone cycle from the next cycle on, and it carries only the low 12 address bits on `wb_adr`. It issues nothing on the memory port.
- R3: A memory command carries the master's address, write data and byte enables unchanged. One cycle after acceptance, the master sees response DVA (code 1), and on a read the data word from `mem_rdata` in that cycle. The response code NULL is 0.
- R4: During a Wishbone cycle, `wb_cyc` and `wb_stb` are high, `wb_we` is set only for WRITE, and `wb_sel` and `wb_dat_o` carry the master's byte enables and data. All of these stay fixed until ACK or ERR is sampled, and CYC and STB are low in the following cycle.
- R5: In the cycle after ACK is sampled (with ERR low), the master sees DVA for exactly one cycle. On a read, `ocp_rdata` holds the word that was on `wb_dat_i` together with ACK.
- R6: In the cycle after ERR is sampled, the master sees response ERR (code 3) instead of DVA. ERR wins over a simultaneous ACK.
- R7: While a Wishbone cycle is open, `ocp_accept` is low, and a command the master presents is neither passed to the memory port nor started. In every other cycle, `ocp_accept` is high.
- R8: An active-low reset, even in the middle of a Wishbone cycle, drops CYC and STB, sets the response to NULL and raises `ocp_accept`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ocp_cmd | input | 3 | Master command (IDLE/WRITE/READ) |
| ocp_addr | input | 16 | Master byte address |
| ocp_wdata | input | 32 | Master write data |
| ocp_be | input | 4 | Master byte enables |
| ocp_accept | output | 1 | Command accepted this cycle |
| ocp_resp | output | 2 | Response code (NULL/DVA/ERR) |
| ocp_rdata | output | 32 | Read data, valid with the response |
| mem_cmd | output | 3 | Command to the frame-buffer memory |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte enables |
| mem_rdata | input | 32 | Memory read data, one cycle after a read |
| wb_cyc | output | 1 | Wishbone cycle |
| wb_stb | output | 1 | Wishbone strobe |
| wb_we | output | 1 | Wishbone write enable |
| wb_adr | output | 12 | Wishbone address |
| wb_sel | output | 4 | Wishbone byte selects |
| wb_dat_o | output | 32 | Wishbone write data |
| wb_dat_i | input | 32 | Wishbone read data |
| wb_ack | input | 1 | Wishbone acknowledge |
| wb_err | input | 1 | Wishbone error |

## Verification
Two functions can fall in the same cycle. One is a memory access response (DVA with `mem_rdata`), and the other is the acceptance of the next command, which may be another memory access or the start of a Wishbone cycle. The bench provokes this by presenting commands back to back with no idle cycle between them. One such sequence is a buffer read followed at once by a window read. A behavioural model predicts every port on every cycle, so it checks both the returned data and the new command's routing in the overlapping cycle. A command held while the Wishbone slave stalls also exercises the hold-off, and a reset applied mid-cycle exercises the abort.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  typedef enum logic [2:0] {
    OCMD_IDLE = 3'd0,
    OCMD_WR   = 3'd1,
    OCMD_RD   = 3'd2
  } ocmd_e;

  typedef enum logic [1:0] {
    ORSP_NULL = 2'd0,
    ORSP_DVA  = 2'd1,
    ORSP_ERR  = 2'd3
  } orsp_e;
endpackage

// File: rtl/win_decode.sv
module win_decode #(
  parameter int unsigned AW     = 16,
  parameter int unsigned WIN_AW = 12
) (
  input  logic [AW-WIN_AW-1:0] tag,
  output logic                 hit_cfg
);
  localparam int unsigned TAG_W = AW - WIN_AW;

  // The window is the top 2**WIN_AW bytes: every tag bit set.
  if (TAG_W == 0) begin : g_all
    assign hit_cfg = 1'b1;
  end else begin : g_tag
    assign hit_cfg = &tag;
  end
endmodule

// File: rtl/wb_cycle_ctrl.sv
module wb_cycle_ctrl #(
  parameter int unsigned WIN_AW = 12,
  parameter int unsigned DW     = 32,
  localparam int unsigned SW    = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_we,
  input  logic [WIN_AW-1:0] start_adr,
  input  logic [SW-1:0]     start_sel,
  input  logic [DW-1:0]     start_dat,
  input  logic              wb_ack,
  input  logic              wb_err,
  output logic              wb_cyc,
  output logic              wb_stb,
  output logic              wb_we,
  output logic [WIN_AW-1:0] wb_adr,
  output logic [SW-1:0]     wb_sel,
  output logic [DW-1:0]     wb_dat_o,
  output logic              busy,
  output logic              done_ok,
  output logic              done_err
);
  logic act_q, act_d;
  logic load_en;
  logic              we_q;
  logic [WIN_AW-1:0] adr_q;
  logic [SW-1:0]     sel_q;
  logic [DW-1:0]     dat_q;

  always_comb begin
    act_d   = act_q;
    load_en = 1'b0;
    if (act_q) begin
      if (wb_ack || wb_err) act_d = 1'b0;
    end else if (start) begin
      act_d   = 1'b1;
      load_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q  <= 1'b0;
      adr_q <= '0;
      sel_q <= '0;
      dat_q <= '0;
    end else if (load_en) begin
      we_q  <= start_we;
      adr_q <= start_adr;
      sel_q <= start_sel;
      dat_q <= start_dat;
    end
  end

  assign wb_cyc   = act_q;
  assign wb_stb   = act_q;
  assign wb_we    = we_q;
  assign wb_adr   = adr_q;
  assign wb_sel   = sel_q;
  assign wb_dat_o = dat_q;
  assign busy     = act_q;
  assign done_ok  = act_q & wb_ack & ~wb_err;
  assign done_err = act_q & wb_err;

  // R4
  hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && !wb_ack && !wb_err) |=> (wb_cyc && wb_stb && $stable(wb_adr)
      && $stable(wb_we) && $stable(wb_sel) && $stable(wb_dat_o)));

  // R4
  cyc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && (wb_ack || wb_err)) |=> !wb_cyc && !wb_stb);
endmodule

// File: rtl/rsp_unit.sv
module rsp_unit #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_go,
  input  logic          wb_ok,
  input  logic          wb_fail,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] wb_dat_i,
  output logic [1:0]    resp,
  output logic [DW-1:0] rdata
);
  import cfgwin_pkg::*;

  orsp_e         rsp_q, rsp_d;
  logic          src_wb_q, src_wb_d;
  logic [DW-1:0] hold_q;
  logic          hold_en;

  always_comb begin
    rsp_d    = ORSP_NULL;
    src_wb_d = src_wb_q;
    hold_en  = 1'b0;
    if (wb_fail) begin
      rsp_d    = ORSP_ERR;
      src_wb_d = 1'b1;
    end else if (wb_ok) begin
      rsp_d    = ORSP_DVA;
      src_wb_d = 1'b1;
      hold_en  = 1'b1;
    end else if (mem_go) begin
      rsp_d    = ORSP_DVA;
      src_wb_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q    <= ORSP_NULL;
      src_wb_q <= 1'b0;
    end else begin
      rsp_q    <= rsp_d;
      src_wb_q <= src_wb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= wb_dat_i;
  end

  assign resp  = rsp_q;
  assign rdata = src_wb_q ? hold_q : mem_rdata;

  // R5
  single_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp != 2'd0) |=> (resp == 2'd0) || $past(mem_go) || $past(wb_ok) || $past(wb_fail));
endmodule

// File: rtl/cfgwin_bridge.sv
module cfgwin_bridge #(
  parameter int unsigned AW     = 16,
  parameter int unsigned DW     = 32,
  parameter int unsigned WIN_AW = 12,
  localparam int unsigned SW    = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        ocp_cmd,
  input  logic [AW-1:0]     ocp_addr,
  input  logic [DW-1:0]     ocp_wdata,
  input  logic [SW-1:0]     ocp_be,
  output logic              ocp_accept,
  output logic [1:0]        ocp_resp,
  output logic [DW-1:0]     ocp_rdata,
  output logic [2:0]        mem_cmd,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic [SW-1:0]     mem_be,
  input  logic [DW-1:0]     mem_rdata,
  output logic              wb_cyc,
  output logic              wb_stb,
  output logic              wb_we,
  output logic [WIN_AW-1:0] wb_adr,
  output logic [SW-1:0]     wb_sel,
  output logic [DW-1:0]     wb_dat_o,
  input  logic [DW-1:0]     wb_dat_i,
  input  logic              wb_ack,
  input  logic              wb_err
);
  import cfgwin_pkg::*;

  logic hit_cfg, busy, done_ok, done_err;
  logic go, cfg_go, mem_go;
  ocmd_e cmd;

  assign cmd = ocmd_e'(ocp_cmd);

  win_decode #(.AW(AW), .WIN_AW(WIN_AW)) u_dec (
    .tag     (ocp_addr[AW-1:WIN_AW]),
    .hit_cfg (hit_cfg)
  );

  assign ocp_accept = ~busy;
  assign go         = ocp_accept && (cmd != OCMD_IDLE);
  assign cfg_go     = go && hit_cfg;
  assign mem_go     = go && !hit_cfg;

  assign mem_cmd   = mem_go ? ocp_cmd : 3'(OCMD_IDLE);
  assign mem_addr  = ocp_addr;
  assign mem_wdata = ocp_wdata;
  assign mem_be    = ocp_be;

  wb_cycle_ctrl #(.WIN_AW(WIN_AW), .DW(DW)) u_wb (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (cfg_go),
    .start_we  (cmd == OCMD_WR),
    .start_adr (ocp_addr[WIN_AW-1:0]),
    .start_sel (ocp_be),
    .start_dat (ocp_wdata),
    .wb_ack    (wb_ack),
    .wb_err    (wb_err),
    .wb_cyc    (wb_cyc),
    .wb_stb    (wb_stb),
    .wb_we     (wb_we),
    .wb_adr    (wb_adr),
    .wb_sel    (wb_sel),
    .wb_dat_o  (wb_dat_o),
    .busy      (busy),
    .done_ok   (done_ok),
    .done_err  (done_err)
  );

  rsp_unit #(.DW(DW)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_go    (mem_go),
    .wb_ok     (done_ok),
    .wb_fail   (done_err),
    .mem_rdata (mem_rdata),
    .wb_dat_i  (wb_dat_i),
    .resp      (ocp_resp),
    .rdata     (ocp_rdata)
  );

  // R1
  mem_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd != 3'd0) |-> (!(&ocp_addr[AW-1:WIN_AW]) && !wb_cyc));

  // R2
  win_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ocp_accept && ocp_cmd != 3'd0 && (&ocp_addr[AW-1:WIN_AW]))
      |=> (wb_cyc && wb_adr == $past(ocp_addr[WIN_AW-1:0])));

  // R3
  mem_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd != 3'd0) |=> (ocp_resp == 2'd1));

  // R5
  ack_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && wb_ack && !wb_err) |=> (ocp_resp == 2'd1 && ocp_rdata == $past(wb_dat_i)));

  // R6
  err_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc && wb_err) |=> (ocp_resp == 2'd3));

  // R7
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc |-> (mem_cmd == 3'd0 && !ocp_accept));
endmodule

// File: tb/cfgwin_bridge_tb.sv
module cfgwin_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ocp_cmd = '0;
  logic [15:0] ocp_addr = '0;
  logic [31:0] ocp_wdata = '0;
  logic [3:0]  ocp_be = '0;
  logic        ocp_accept;
  logic [1:0]  ocp_resp;
  logic [31:0] ocp_rdata;
  logic [2:0]  mem_cmd;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata = '0;
  logic        wb_cyc, wb_stb, wb_we;
  logic [11:0] wb_adr;
  logic [3:0]  wb_sel;
  logic [31:0] wb_dat_o;
  logic [31:0] wb_dat_i = '0;
  logic        wb_ack = 1'b0;
  logic        wb_err = 1'b0;

  always #2 clk = ~clk;

  cfgwin_bridge u_dut (
    .clk(clk), .rst_n(rst_n),
    .ocp_cmd(ocp_cmd), .ocp_addr(ocp_addr), .ocp_wdata(ocp_wdata), .ocp_be(ocp_be),
    .ocp_accept(ocp_accept), .ocp_resp(ocp_resp), .ocp_rdata(ocp_rdata),
    .mem_cmd(mem_cmd), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_rdata(mem_rdata),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr), .wb_sel(wb_sel),
    .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_ack(wb_ack), .wb_err(wb_err)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int sl_lat = 0;
  bit sl_err = 1'b0;
  int wcnt = 0;

  // Behavioural model state
  bit          m_busy = 1'b0;
  bit          m_we = 1'b0;
  bit          m_wb_rd = 1'b0;
  logic [11:0] m_adr = '0;
  logic [3:0]  m_sel = '0;
  logic [31:0] m_wdat = '0;
  int          m_resp = 0;
  bit          m_rd = 1'b0;
  logic [31:0] m_rdx = '0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Frame-buffer memory: registered read, one cycle latency
  always @(posedge clk) begin
    if (mem_cmd == 3'd2) mem_rdata <= {~mem_addr, mem_addr};
  end

  // Wishbone slave with programmable wait states
  always @(negedge clk) begin
    wb_ack = 1'b0;
    wb_err = 1'b0;
    wb_dat_i = {8'hC5, 12'h000, wb_adr};
    if (wb_cyc && wb_stb) begin
      if (wcnt >= sl_lat) begin
        if (sl_err) wb_err = 1'b1;
        else        wb_ack = 1'b1;
        wcnt = 0;
      end else begin
        wcnt++;
      end
    end else begin
      wcnt = 0;
    end
  end

  // Reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 1'b0;
      m_resp = 0;
      m_rd   = 1'b0;
    end else begin
      m_resp = 0;
      m_rd   = 1'b0;
      if (m_busy) begin
        if (wb_err) begin
          m_busy = 1'b0;
          m_resp = 3;
        end else if (wb_ack) begin
          m_busy = 1'b0;
          m_resp = 1;
          m_rd   = m_wb_rd;
          m_rdx  = {8'hC5, 12'h000, m_adr};
        end
      end else if (ocp_cmd != 3'd0) begin
        if (ocp_addr >= 16'hF000) begin
          m_busy  = 1'b1;
          m_we    = (ocp_cmd == 3'd1);
          m_wb_rd = (ocp_cmd == 3'd2);
          m_adr   = ocp_addr[11:0];
          m_sel   = ocp_be;
          m_wdat  = ocp_wdata;
        end else begin
          m_resp = 1;
          m_rd   = (ocp_cmd == 3'd2);
          m_rdx  = {~ocp_addr, ocp_addr};
        end
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always begin
    @(negedge clk);
    #1;
    if (rst_n && !finished) begin
      chk("R7 ocp_accept", 32'(ocp_accept), 32'(!m_busy));
      chk("R1 mem_cmd", 32'(mem_cmd),
          (!m_busy && ocp_cmd != 3'd0 && ocp_addr < 16'hF000) ? 32'(ocp_cmd) : 32'd0);
      if (mem_cmd != 3'd0) begin
        chk("R3 mem_addr", 32'(mem_addr), 32'(ocp_addr));
        chk("R3 mem_wdata", mem_wdata, ocp_wdata);
        chk("R3 mem_be", 32'(mem_be), 32'(ocp_be));
      end
      chk("R2 R4 wb_cyc", 32'(wb_cyc), 32'(m_busy));
      chk("R4 wb_stb", 32'(wb_stb), 32'(m_busy));
      if (m_busy) begin
        chk("R2 wb_adr", 32'(wb_adr), 32'(m_adr));
        chk("R4 wb_we", 32'(wb_we), 32'(m_we));
        chk("R4 wb_sel", 32'(wb_sel), 32'(m_sel));
        chk("R4 wb_dat_o", wb_dat_o, m_wdat);
      end
      chk("R3 R5 R6 ocp_resp", 32'(ocp_resp), 32'(m_resp));
      if (m_rd) chk("R3 R5 ocp_rdata", ocp_rdata, m_rdx);
    end
  end

  task automatic issue(logic [2:0] c, logic [15:0] a, logic [31:0] d, logic [3:0] b);
    @(negedge clk);
    ocp_cmd = c; ocp_addr = a; ocp_wdata = d; ocp_be = b;
    #1;
    while (!ocp_accept) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    ocp_cmd = 3'd0;
    repeat (n) @(negedge clk);
  endtask

  task automatic reset_checks();
    chk("R8 ocp_resp", 32'(ocp_resp), 32'd0);
    chk("R8 wb_cyc", 32'(wb_cyc), 32'd0);
    chk("R8 wb_stb", 32'(wb_stb), 32'd0);
    chk("R8 ocp_accept", 32'(ocp_accept), 32'd1);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    reset_checks();
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R3: buffer accesses, including region edges, back to back
    issue(3'd1, 16'h0000, 32'h1111_2222, 4'hF);
    issue(3'd2, 16'h1234, 32'h0, 4'hF);
    issue(3'd2, 16'hEFFF, 32'h0, 4'h3);
    issue(3'd2, 16'h0004, 32'h0, 4'hF);
    idle(2);

    // R2 R4 R7: window write, then a buffer read held while the cycle is open
    sl_lat = 0;
    issue(3'd1, 16'hF000, 32'hDEAD_BEEF, 4'b0101);
    issue(3'd2, 16'h0010, 32'h0, 4'hF);
    idle(3);

    // R5: window read with wait states at the top address
    sl_lat = 3;
    issue(3'd2, 16'hFFFF, 32'h0, 4'hF);
    idle(6);

    // Buffer response overlapping a window start
    sl_lat = 1;
    issue(3'd2, 16'h0100, 32'h0, 4'hF);
    issue(3'd2, 16'hF7A4, 32'h0, 4'hF);
    idle(5);

    // R6: error completion, then a held buffer read
    sl_err = 1'b1;
    sl_lat = 2;
    issue(3'd1, 16'hF123, 32'hCAFE_0001, 4'b1000);
    issue(3'd2, 16'h0200, 32'h0, 4'hF);
    idle(4);
    sl_err = 1'b0;

    sl_lat = 2;
    issue(3'd2, 16'hF800, 32'h0, 4'hF);
    idle(5);

    // R8: reset in the middle of a stalled window cycle
    sl_lat = 8;
    issue(3'd2, 16'hF004, 32'h0, 4'hF);
    idle(2);
    rst_n = 1'b0;
    #1;
    reset_checks();
    @(negedge clk);
    rst_n = 1'b1;
    sl_lat = 0;
    issue(3'd2, 16'h0040, 32'h0, 4'hF);
    idle(3);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule